// File: doc/BRIEF.md
# Writeback-Aware Cache Utility Monitor

This block watches the access stream that one core sends to a shared set-associative cache. It keeps a small shadow directory for a fixed subset of the cache sets and measures how useful each extra way would be to that core. For every shadow hit it records the LRU stack distance of the line. It also tracks, for each line that a write has dirtied, the deepest stack position the line reached before the next write arrives. That depth is the smallest way budget at which the later write would have merged into the dirty line instead of causing a writeback.

Two banks of saturating counters, one entry per stack distance, collect these results. One bank counts hits and the other counts writebacks that could have been avoided. A partitioning controller reads both banks through a combinational read port, one stack position at a time. It clears them at every epoch boundary.

Accesses go through a two-stage pipeline: a request register followed by a lookup and update stage. An access to the shadow set that is already being updated is held off for one cycle by the ready signal.

Top module: `wb_util_monitor`

## Requirements
- R1: An access is sampled only when the low SAMPLE_LOG bits of its set index are zero, and its shadow set is the remaining upper bits. An unsampled access is always accepted (ready high) and changes no counter and no shadow state.
- R2: The stack distance of a hit is the number of distinct other tags accessed in that shadow set since the last access to the hit tag (0 = most recent). A hit increments hit counter sd.
- R3: A miss installs the tag in an empty way, or if the set is full in the least recently used way, and the new entry becomes most recent. A miss changes no counter.
- R4: A write sets the dirty flag of the accessed entry, a read leaves it unchanged, and a filled entry is dirty exactly when the fill was a write.
- R5: A hit on a dirty entry raises its avoidance distance to the larger of its current value and the hit's stack distance. Every fill starts with avoidance distance 0.
- R6: A write hit on a dirty entry increments avoidable-writeback counter number wad (after the R5 update) and then resets wad to 0. A write hit on a clean entry increments no avoidable-writeback counter.
- R7: Every counter stops at 2^CNT_W-1, and on each cycle a counter either holds its value or grows by exactly one.
- R8: A one-cycle pulse of clr_i zeroes all counters on the next edge, even when an update lands on that same edge. Shadow state is kept.
- R9: An access accepted at edge k updates the counters at edge k+1. When the access presented in the cycle after an acceptance maps to the same shadow set, acc_ready_o is low for exactly that one cycle. An access to a different shadow set is not stalled.
- R10: rd_hit_o and rd_awb_o show, without delay, the counters at stack position rd_sel_i.
- R11: After reset all counters read 0, every shadow set is empty, and acc_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe |
| acc_ready_o | output | 1 | Access accepted this cycle when high |
| acc_set_i | input | SET_W | Cache set index of the access |
| acc_tag_i | input | TAG_W | Tag of the access |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| clr_i | input | 1 | Epoch clear of both counter banks |
| rd_sel_i | input | log2(WAYS) | Stack position to read |
| rd_hit_o | output | CNT_W | Hit counter at rd_sel_i |
| rd_awb_o | output | CNT_W | Avoidable-writeback counter at rd_sel_i |

## Verification
The hardest case to reach is an avoidable writeback counted at a non-zero distance. It needs a dirty line that sinks several stack positions, is touched again by a read, and is then hit by a write. The bench builds this directly. It writes a tag, pushes it down with reads of other tags in the same sampled set, reads it back at depth two, and then writes it. It also includes a write hit on a line that was filled by a read, which must leave the writeback bank untouched. A reference model keeps each shadow set as a most-recent-first list and predicts both banks after every sequence.

// File: rtl/wum_pkg.sv
`timescale 1ns/1ps
package wum_pkg;
  typedef enum logic {ACC_RD = 1'b0, ACC_WR = 1'b1} acc_kind_e;
endpackage

// File: rtl/wum_cnt_bank.sv
`timescale 1ns/1ps
module wum_cnt_bank #(
  parameter int N     = 4,
  parameter int IDX_W = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [IDX_W-1:0] inc_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_cnt_o
);
  logic [CNT_W-1:0] cnt [N];

  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      cnt_q <= '0;
      else if (clr_i)                                   cnt_q <= '0;
      else if (inc_i && inc_idx_i == IDX_W'(g) && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
    assign cnt[g] = cnt_q;
  end

  assign rd_cnt_o = cnt[rd_idx_i];
endmodule

// File: rtl/wum_shadow_dir.sv
`timescale 1ns/1ps
module wum_shadow_dir #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 12,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_IW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [SET_IW-1:0] set_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              wr_i,
  output logic              hit_o,
  output logic [WAY_W-1:0]  sd_o,
  output logic [WAY_W-1:0]  wad_o,
  output logic              dirty_o
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAY_W-1:0] pos_q [SETS][WAYS];
  logic [WAY_W-1:0] wad_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  dty_q [SETS];

  logic [WAYS-1:0]  hit_vec, vic_vec, sel_vec;
  logic [WAY_W-1:0] sel_way, old_pos, wad_cur, wad_max;
  logic             dty_cur, hit;

  always_comb begin
    hit_vec = '0;
    vic_vec = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_q[set_i][w] && (tag_q[set_i][w] == tag_i);
      vic_vec[w] = (pos_q[set_i][w] == WAY_W'(WAYS - 1));
    end
  end

  assign hit     = |hit_vec;
  assign sel_vec = hit ? hit_vec : vic_vec;

  always_comb begin
    sel_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (sel_vec[w]) sel_way = WAY_W'(w);
  end

  // on a miss the victim sits at the bottom, so old_pos is WAYS-1
  assign old_pos = pos_q[set_i][sel_way];
  assign wad_cur = wad_q[set_i][sel_way];
  assign dty_cur = dty_q[set_i][sel_way];
  assign wad_max = (dty_cur && old_pos > wad_cur) ? old_pos : wad_cur;

  assign hit_o   = hit;
  assign sd_o    = old_pos;
  assign wad_o   = wad_max;
  assign dirty_o = dty_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          pos_q[s][w] <= WAY_W'(w);
          wad_q[s][w] <= '0;
        end
      end
    end else if (upd_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == sel_way) begin
          pos_q[set_i][w] <= '0;
          if (hit) begin
            if (wr_i) begin
              wad_q[set_i][w] <= '0;
              dty_q[set_i][w] <= 1'b1;
            end else begin
              wad_q[set_i][w] <= wad_max;
            end
          end else begin
            tag_q[set_i][w] <= tag_i;
            vld_q[set_i][w] <= 1'b1;
            dty_q[set_i][w] <= wr_i;
            wad_q[set_i][w] <= '0;
          end
        end else if (pos_q[set_i][w] < old_pos) begin
          pos_q[set_i][w] <= pos_q[set_i][w] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wb_util_monitor.sv
`timescale 1ns/1ps
module wb_util_monitor
  import wum_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int SET_W      = 6,
  parameter int TAG_W      = 12,
  parameter int SAMPLE_LOG = 2,
  parameter int CNT_W      = 16,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SH_W  = SET_W - SAMPLE_LOG,
  localparam int SETS  = 1 << SH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  output logic             acc_ready_o,
  input  logic [SET_W-1:0] acc_set_i,
  input  logic [TAG_W-1:0] acc_tag_i,
  input  logic             acc_wr_i,
  input  logic             clr_i,
  input  logic [WAY_W-1:0] rd_sel_i,
  output logic [CNT_W-1:0] rd_hit_o,
  output logic [CNT_W-1:0] rd_awb_o
);
  logic            acc_sampled;
  logic [SH_W-1:0] acc_shset;

  if (SAMPLE_LOG == 0) begin : g_all_sets
    assign acc_sampled = 1'b1;
    assign acc_shset   = acc_set_i;
  end else begin : g_sub_sets
    assign acc_sampled = (acc_set_i[SAMPLE_LOG-1:0] == '0);
    assign acc_shset   = acc_set_i[SET_W-1:SAMPLE_LOG];
  end

  logic             pend_vld_q;
  logic [SH_W-1:0]  pend_set_q;
  logic [TAG_W-1:0] pend_tag_q;
  acc_kind_e        pend_kind_q;
  logic             accept;

  // hold off a same-set access while that set is in its update cycle
  assign acc_ready_o = !(pend_vld_q && acc_sampled && (acc_shset == pend_set_q));
  assign accept      = acc_valid_i && acc_ready_o && acc_sampled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q  <= 1'b0;
      pend_set_q  <= '0;
      pend_tag_q  <= '0;
      pend_kind_q <= ACC_RD;
    end else begin
      pend_vld_q <= accept;
      if (accept) begin
        pend_set_q  <= acc_shset;
        pend_tag_q  <= acc_tag_i;
        pend_kind_q <= acc_wr_i ? ACC_WR : ACC_RD;
      end
    end
  end

  logic             dir_hit, dir_dirty;
  logic [WAY_W-1:0] dir_sd, dir_wad;
  logic             pend_wr;

  assign pend_wr = (pend_kind_q == ACC_WR);

  wum_shadow_dir #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) dir_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (pend_vld_q),
    .set_i   (pend_set_q),
    .tag_i   (pend_tag_q),
    .wr_i    (pend_wr),
    .hit_o   (dir_hit),
    .sd_o    (dir_sd),
    .wad_o   (dir_wad),
    .dirty_o (dir_dirty)
  );

  logic hit_inc, awb_inc;
  assign hit_inc = pend_vld_q && dir_hit;
  assign awb_inc = pend_vld_q && dir_hit && pend_wr && dir_dirty;

  wum_cnt_bank #(.N(WAYS), .IDX_W(WAY_W), .CNT_W(CNT_W)) hit_bank_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .inc_i     (hit_inc),
    .inc_idx_i (dir_sd),
    .rd_idx_i  (rd_sel_i),
    .rd_cnt_o  (rd_hit_o)
  );

  wum_cnt_bank #(.N(WAYS), .IDX_W(WAY_W), .CNT_W(CNT_W)) awb_bank_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .inc_i     (awb_inc),
    .inc_idx_i (dir_wad),
    .rd_idx_i  (rd_sel_i),
    .rd_cnt_o  (rd_awb_o)
  );
endmodule

// File: rtl/wum_checker.sv
`timescale 1ns/1ps
module wum_checker #(
  parameter int WAYS       = 4,
  parameter int SET_W      = 6,
  parameter int SAMPLE_LOG = 2,
  parameter int CNT_W      = 16,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic             acc_ready_o,
  input logic [SET_W-1:0] acc_set_i,
  input logic             clr_i,
  input logic [WAY_W-1:0] rd_sel_i,
  input logic [CNT_W-1:0] rd_hit_o,
  input logic [CNT_W-1:0] rd_awb_o
);
  logic unsampled;
  assign unsampled = (acc_set_i & SET_W'((1 << SAMPLE_LOG) - 1)) != '0;

  AST_UNSAMPLED_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && unsampled |-> acc_ready_o); // R1

  AST_STALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_ready_o |-> $past(acc_valid_i && acc_ready_o)); // R9

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_ready_o |=> acc_ready_o); // R9

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (rd_hit_o == '0 && rd_awb_o == '0)); // R8

  AST_HIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(rd_sel_i) && !$past(clr_i) |->
      (rd_hit_o == $past(rd_hit_o) ||
       (rd_hit_o > $past(rd_hit_o) && rd_hit_o - $past(rd_hit_o) == CNT_W'(1)))); // R7

  AST_AWB_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(rd_sel_i) && !$past(clr_i) |->
      (rd_awb_o == $past(rd_awb_o) ||
       (rd_awb_o > $past(rd_awb_o) && rd_awb_o - $past(rd_awb_o) == CNT_W'(1)))); // R7
endmodule

bind wb_util_monitor wum_checker #(
  .WAYS(WAYS), .SET_W(SET_W), .SAMPLE_LOG(SAMPLE_LOG), .CNT_W(CNT_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_ready_o (acc_ready_o),
  .acc_set_i   (acc_set_i),
  .clr_i       (clr_i),
  .rd_sel_i    (rd_sel_i),
  .rd_hit_o    (rd_hit_o),
  .rd_awb_o    (rd_awb_o)
);

// File: tb/wb_util_monitor_tb_top.sv
`timescale 1ns/1ps
module wb_util_monitor_tb_top;
  localparam int WAYS = 4, SET_W = 6, TAG_W = 8, SAMPLE_LOG = 2, CNT_W = 4;
  localparam int WAY_W = $clog2(WAYS);
  localparam int SETS = 1 << (SET_W - SAMPLE_LOG);
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic acc_valid_i = 1'b0, acc_wr_i = 1'b0, clr_i = 1'b0, acc_ready_o;
  logic [SET_W-1:0] acc_set_i = '0;
  logic [TAG_W-1:0] acc_tag_i = '0;
  logic [WAY_W-1:0] rd_sel_i = '0;
  logic [CNT_W-1:0] rd_hit_o, rd_awb_o;

  always #2 clk = ~clk;

  wb_util_monitor #(.WAYS(WAYS), .SET_W(SET_W), .TAG_W(TAG_W),
                    .SAMPLE_LOG(SAMPLE_LOG), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .acc_valid_i(acc_valid_i), .acc_ready_o(acc_ready_o),
    .acc_set_i(acc_set_i), .acc_tag_i(acc_tag_i), .acc_wr_i(acc_wr_i), .clr_i(clr_i),
    .rd_sel_i(rd_sel_i), .rd_hit_o(rd_hit_o), .rd_awb_o(rd_awb_o));

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model: per shadow set, most-recent-first list
  typedef struct { int tag; bit dty; int wad; } ment_t;
  ment_t mdl [SETS][$];
  int m_hit [WAYS];
  int m_awb [WAYS];

  typedef struct { string req; int way; int ehit; int eawb; } item_t;
  item_t sb_q[$];

  task automatic model_acc(input int set, input int tag, input bit wr);
    int s, idx;
    ment_t e;
    if (set % (1 << SAMPLE_LOG) != 0) return;
    s = set >> SAMPLE_LOG;
    idx = -1;
    foreach (mdl[s][i]) if (idx < 0 && mdl[s][i].tag == tag) idx = i;
    if (idx >= 0) begin
      e = mdl[s][idx];
      if (m_hit[idx] < CMAX) m_hit[idx]++;
      if (e.dty && idx > e.wad) e.wad = idx;
      if (wr) begin
        if (e.dty && m_awb[e.wad] < CMAX) m_awb[e.wad]++;
        e.wad = 0;
        e.dty = 1;
      end
      mdl[s].delete(idx);
      mdl[s].push_front(e);
    end else begin
      if (mdl[s].size() == WAYS) void'(mdl[s].pop_back());
      e.tag = tag; e.dty = wr; e.wad = 0;
      mdl[s].push_front(e);
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_acc(input int set, input int tag, input bit wr, output int stalls);
    @(negedge clk);
    acc_valid_i = 1'b1; acc_set_i = SET_W'(set); acc_tag_i = TAG_W'(tag); acc_wr_i = wr;
    #1;
    stalls = 0;
    while (!acc_ready_o) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(posedge clk);
    model_acc(set, tag, wr);
  endtask

  task automatic acc(input int set, input int tag, input bit wr);
    int st;
    do_acc(set, tag, wr, st);
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid_i = 1'b0;
  endtask

  // R10: each stack position read back through rd_sel_i
  task automatic chk_counters(input string req);
    item_t it;
    idle();
    @(negedge clk);
    for (int w = 0; w < WAYS; w++) begin
      @(negedge clk);
      rd_sel_i = WAY_W'(w);
      it.req = req; it.way = w; it.ehit = m_hit[w]; it.eawb = m_awb[w];
      sb_q.push_back(it);
    end
    @(negedge clk); #2;
  endtask

  task automatic clear_epoch();
    @(negedge clk);
    acc_valid_i = 1'b0; clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    for (int w = 0; w < WAYS; w++) begin m_hit[w] = 0; m_awb[w] = 0; end
  endtask

  // scoreboard monitor
  always begin
    item_t it;
    @(negedge clk); #1;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      checks++;
      if (rd_hit_o != CNT_W'(it.ehit) || rd_awb_o != CNT_W'(it.eawb)) begin
        errors++;
        $display("FAIL %s pos %0d hit actual %0d expected %0d awb actual %0d expected %0d",
                 it.req, it.way, rd_hit_o, it.ehit, rd_awb_o, it.eawb);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int st, base;
    for (int w = 0; w < WAYS; w++) begin m_hit[w] = 0; m_awb[w] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    check(acc_ready_o === 1'b1, "R11 ready after reset", acc_ready_o, 1);
    chk_counters("R11 reset counters");

    // R3 fills then R2 hits at several depths
    acc(0, 10, 0); acc(0, 11, 0); acc(0, 12, 0); acc(0, 13, 0);
    chk_counters("R3 fills count nothing");
    acc(0, 13, 0); acc(0, 10, 0); acc(0, 10, 0); acc(0, 12, 0); acc(0, 11, 0);
    chk_counters("R2 stack distances");
    // R3 eviction of least recent
    acc(0, 14, 0); acc(0, 13, 0); acc(0, 14, 0);
    chk_counters("R3 eviction and refill");

    // R4 R5 R6 dirty line reaches depth 2 before write
    acc(4, 20, 1); acc(4, 21, 0); acc(4, 22, 0); acc(4, 20, 0); acc(4, 20, 1);
    chk_counters("R5 R6 avoidance distance 2");
    acc(4, 20, 1);
    chk_counters("R6 wad cleared after write");
    // R4 R6 clean fill, write hit counts no writeback
    acc(8, 30, 0); acc(8, 31, 0); acc(8, 30, 1);
    chk_counters("R4 R6 write on clean line");
    acc(8, 31, 0); acc(8, 30, 1);
    chk_counters("R4 R5 dirty after write");

    // R1 unsampled sets ignored
    clear_epoch();
    for (int k = 1; k < 4; k++) begin
      do_acc(k, 10, 1, st);
      check(st == 0, "R1 unsampled not stalled", st, 0);
      do_acc(k + 4, 20, 1, st);
    end
    chk_counters("R1 unsampled no effect");
    acc(0, 11, 0);
    chk_counters("R1 shadow state untouched");

    // R9 stalls
    idle();
    do_acc(0, 12, 0, st);
    do_acc(0, 13, 0, st);
    check(st == 1, "R9 same-set stall", st, 1);
    do_acc(4, 21, 0, st);
    check(st == 0, "R9 other set no stall", st, 0);
    do_acc(0, 14, 0, st);
    check(st == 0, "R9 back to first set no stall", st, 0);
    chk_counters("R9 counters after stream");

    // R7 saturation
    for (int k = 0; k < 20; k++) acc(8, 40, 0);
    chk_counters("R7 hit saturation");
    for (int k = 0; k < 20; k++) acc(8, 40, 1);
    chk_counters("R7 awb saturation");

    // R8 clear
    clear_epoch();
    chk_counters("R8 clear");

    // R9 latency
    idle();
    @(negedge clk); rd_sel_i = '0;
    #1 base = rd_hit_o;
    acc(8, 40, 0);
    @(negedge clk); acc_valid_i = 1'b0; #1;
    check(rd_hit_o == CNT_W'(base), "R9 not yet counted", rd_hit_o, base);
    @(negedge clk); #1;
    check(rd_hit_o == CNT_W'(base + 1), "R9 counted one edge later", rd_hit_o, base + 1);

    // R8 clear wins over concurrent update
    acc(8, 40, 1);
    @(negedge clk);
    acc_valid_i = 1'b0; clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    for (int w = 0; w < WAYS; w++) begin m_hit[w] = 0; m_awb[w] = 0; end
    chk_counters("R8 clear beats update");
    acc(8, 40, 0);
    chk_counters("R8 shadow kept across clear");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule